// File: doc/BRIEF.md
# Programmable Sum-of-Products Array

This block is a small programmable logic array that computes sum-of-products functions and registers them. It has `N_IN` logic inputs, `N_PT` product terms and `N_OUT` registered outputs. Each product term is the AND of a chosen set of literals. Every input is offered to every term twice, once as itself and once inverted. Each output is then the OR of a set of product terms, and that OR is captured in a flip-flop that drives the output port.

The connection pattern is held in a configuration chain. The chain loads serially, one bit per clock, while `cfg_en` is high, and keeps its contents while `cfg_en` is low. The parameter `MODE` selects one of two variants:

- **Full mode** (`PLANE_FULL`): the OR plane is also programmable, so any product term may feed any number of outputs.
- **Fixed-OR mode** (`PLANE_FIXED_OR`): each output owns a fixed, contiguous group of terms. The OR-plane bits of the chain are still shifted through, but they have no effect.

Top module: `sop_logic_array`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs and the whole configuration chain clear to 0. After reset, a term with no connections evaluates to 1 and an output with no connected terms evaluates to 0. In full mode all outputs therefore read 0; in fixed-OR mode all outputs read 1.
- R2: The configuration holds `N_PT*2*N_IN + N_OUT*N_PT` bits. The j-th bit shifted in lands at chain index j. AND-plane bits come first, so the OR-plane bits come last.
- R3: While `cfg_en` is high at an edge, the chain shifts by one bit and the outputs register 0.
- R4: Chain index `t*2*N_IN + 2*i` connects input i to term t. Index `t*2*N_IN + 2*i + 1` connects the inverse of input i to term t. A term is the AND of its connected literals, and it is 1 when it has no connected literals.
- R5: In full mode, index `N_PT*2*N_IN + k*N_PT + t` connects term t to output k. Output k is the OR of its connected terms, and it is 0 when no term is connected.
- R6: In full mode, one product term may feed several outputs at once.
- R7: In fixed-OR mode, output k is the OR of terms `k*(N_PT/N_OUT)` to `(k+1)*(N_PT/N_OUT)-1`. The OR-plane bits of the chain have no effect.
- R8: Each output shows, one clock later, the sum-of-products of the inputs sampled at the previous edge.
- R9: While `cfg_en` is low, `cfg_din` has no effect and the configuration holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration bit |
| in_vec | input | N_IN | Logic inputs |
| q_out | output | N_OUT | Registered sum-of-products outputs |

## Verification
The bench loads one pattern into a full-mode instance and a fixed-OR instance side by side. Output 0 is programmed as ab + a'c. In full mode, output 1 is a'c + b'c', which shares the a'c term. All eight input combinations are swept through both instances:
- The full-mode instance tells apart true and inverted literals and shows the term sharing.
- The fixed-OR instance shows the group wiring, and shows that an empty term in a group forces its output to 1.

A second pattern with every OR-plane bit cleared separates the two modes: full-mode outputs fall to 0, while fixed-OR outputs do not change. A reset taken after loading shows that the chain clears. Toggling `cfg_din` with `cfg_en` low shows that the configuration holds.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic {
    PLANE_FULL     = 1'b0,
    PLANE_FIXED_OR = 1'b1
  } or_mode_e;

  // Number of AND-plane bits.
  function automatic int and_bits(input int n_in, input int n_pt);
    return n_pt * 2 * n_in;
  endfunction

  // Number of OR-plane bits.
  function automatic int or_bits(input int n_pt, input int n_out);
    return n_out * n_pt;
  endfunction

  // Chain index for a literal: term t, input i, inverted when neg is 1.
  function automatic int lit_index(input int n_in, input int t, input int i, input bit neg);
    return t * 2 * n_in + 2 * i + int'(neg);
  endfunction

endpackage

// File: rtl/cfg_chain.sv
module cfg_chain #(
  parameter int LEN = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en,
  input  logic           din,
  output logic [LEN-1:0] bits
);
  // The first bit shifted in ends at index 0.
  always_ff @(posedge clk) begin
    if (rst)
      bits <= '0;
    else if (shift_en)
      bits <= {din, bits[LEN-1:1]};
  end
endmodule

// File: rtl/and_plane.sv
module and_plane #(
  parameter int N_IN = 3,
  parameter int N_PT = 4,
  localparam int COLS = 2 * N_IN
) (
  input  logic [N_IN-1:0]      in_vec,
  input  logic [N_PT*COLS-1:0] mask,
  output logic [N_PT-1:0]      terms
);
  logic [COLS-1:0] lits;

  // Literal columns alternate: true form, then inverted form.
  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lits[2*i]   = in_vec[i];
    assign lits[2*i+1] = ~in_vec[i];
  end

  // A column that is not connected reads as 1, so an empty term is 1.
  for (genvar t = 0; t < N_PT; t++) begin : g_term
    assign terms[t] = &(lits | ~mask[t*COLS +: COLS]);
  end
endmodule

// File: rtl/or_plane.sv
module or_plane #(
  parameter int N_PT = 4,
  parameter int N_OUT = 2,
  parameter pla_pkg::or_mode_e MODE = pla_pkg::PLANE_FULL,
  localparam int GRP = N_PT / N_OUT
) (
  input  logic [N_PT-1:0]       terms,
  input  logic [N_OUT*N_PT-1:0] mask,
  output logic [N_OUT-1:0]      sop
);
  if (MODE == pla_pkg::PLANE_FULL) begin : g_full
    // Every term can reach every output.
    for (genvar k = 0; k < N_OUT; k++) begin : g_out
      assign sop[k] = |(terms & mask[k*N_PT +: N_PT]);
    end
  end else begin : g_fixed
    // Each output owns one fixed group of terms; the mask is not used.
    logic mask_unused;
    assign mask_unused = ^mask;
    for (genvar k = 0; k < N_OUT; k++) begin : g_out
      assign sop[k] = |terms[k*GRP +: GRP];
    end
  end
endmodule

// File: rtl/macrocell_bank.sv
module macrocell_bank #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || hold)
      q <= '0;
    else
      q <= d;
  end
endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array #(
  parameter int N_IN = 3,
  parameter int N_PT = 4,
  parameter int N_OUT = 2,
  parameter pla_pkg::or_mode_e MODE = pla_pkg::PLANE_FULL,
  localparam int AND_W = pla_pkg::and_bits(N_IN, N_PT),
  localparam int OR_W  = pla_pkg::or_bits(N_PT, N_OUT),
  localparam int TOT   = AND_W + OR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_din,
  input  logic [N_IN-1:0]  in_vec,
  output logic [N_OUT-1:0] q_out
);
  logic [TOT-1:0]   cfg_bits;
  logic [AND_W-1:0] and_mask;
  logic [OR_W-1:0]  or_mask;
  logic [N_PT-1:0]  terms;
  logic [N_OUT-1:0] sop;

  cfg_chain #(.LEN(TOT)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_en (cfg_en),
    .din      (cfg_din),
    .bits     (cfg_bits)
  );

  assign and_mask = cfg_bits[AND_W-1:0];
  assign or_mask  = cfg_bits[TOT-1:AND_W];

  and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
    .in_vec (in_vec),
    .mask   (and_mask),
    .terms  (terms)
  );

  or_plane #(.N_PT(N_PT), .N_OUT(N_OUT), .MODE(MODE)) u_or (
    .terms (terms),
    .mask  (or_mask),
    .sop   (sop)
  );

  macrocell_bank #(.W(N_OUT)) u_mc (
    .clk  (clk),
    .rst  (rst),
    .hold (cfg_en),
    .d    (sop),
    .q    (q_out)
  );
endmodule

// File: rtl/sop_logic_array_chk.sv
module sop_logic_array_chk #(
  parameter int TOT = 32,
  parameter int OR_W = 8,
  parameter int N_OUT = 2,
  parameter bit FULL = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_en,
  input logic             cfg_din,
  input logic [TOT-1:0]   cfg_bits,
  input logic [OR_W-1:0]  or_mask,
  input logic [N_OUT-1:0] sop,
  input logic [N_OUT-1:0] q_out
);
  // R1: reset clears the outputs and the chain.
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (q_out == '0 && cfg_bits == '0));

  // R3: loading forces the outputs to 0.
  p_load_zero_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> q_out == '0);

  // R3: each load cycle moves the new bit to the top of the chain.
  p_shift_in_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> cfg_bits[TOT-1] == $past(cfg_din));

  // R9: the chain holds while loading is off.
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(cfg_bits));

  // R8: the output is the previous cycle's combinational sum.
  p_reg_sop_r8: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> q_out == $past(sop));

  // R5: in full mode, an empty OR plane gives all-zero sums.
  p_empty_or_r5: assert property (@(posedge clk) disable iff (rst)
    (FULL && or_mask == '0) |-> sop == '0);
endmodule

bind sop_logic_array sop_logic_array_chk #(
  .TOT   (TOT),
  .OR_W  (OR_W),
  .N_OUT (N_OUT),
  .FULL  (MODE == pla_pkg::PLANE_FULL)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_en   (cfg_en),
  .cfg_din  (cfg_din),
  .cfg_bits (cfg_bits),
  .or_mask  (or_mask),
  .sop      (sop),
  .q_out    (q_out)
);

// File: tb/sim_sop_logic_array.sv
module sim_sop_logic_array;
  localparam int NB = 32;

  // Pattern A. Output 0 = ab + a'c; full-mode output 1 = a'c + b'c'.
  // a = in[0], b = in[1], c = in[2].
  // Term 0: a, b.  Term 1: a', c.  Term 2: b', c'.  Term 3: empty.
  localparam logic [NB-1:0] CFG_A =
      (32'd1 << 0) | (32'd1 << 2)              // R4: term 0 = a & b
    | (32'd1 << 7) | (32'd1 << 10)             // R4: term 1 = a' & c
    | (32'd1 << 15) | (32'd1 << 17)            // R4: term 2 = b' & c'
    | (32'd1 << 24) | (32'd1 << 25)            // R5: output 0 <- terms 0, 1
    | (32'd1 << 29) | (32'd1 << 30);           // R6: output 1 <- terms 1, 2

  // Pattern B: pattern A with every OR-plane bit cleared.
  localparam logic [NB-1:0] CFG_B = CFG_A & 32'h00FF_FFFF;

  // Vector table: {in[2:0], expected full-mode q[1:0], expected fixed-OR q[1:0]}.
  localparam logic [6:0] VEC [8] = '{
    {3'd0, 2'b10, 2'b10}, {3'd1, 2'b10, 2'b10},
    {3'd2, 2'b00, 2'b10}, {3'd3, 2'b01, 2'b11},
    {3'd4, 2'b11, 2'b11}, {3'd5, 2'b00, 2'b10},
    {3'd6, 2'b11, 2'b11}, {3'd7, 2'b01, 2'b11}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 1'b0;
  logic cfg_din = 1'b0;
  logic [2:0] in_vec = '0;
  logic [1:0] q_full, q_fix;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sop_logic_array #(.N_IN(3), .N_PT(4), .N_OUT(2), .MODE(pla_pkg::PLANE_FULL)) u0 (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .in_vec(in_vec), .q_out(q_full));

  sop_logic_array #(.N_IN(3), .N_PT(4), .N_OUT(2), .MODE(pla_pkg::PLANE_FIXED_OR)) u1 (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .in_vec(in_vec), .q_out(q_fix));

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // Shifts in a whole pattern. The outputs must stay 0 throughout (R3).
  task automatic load(input logic [NB-1:0] cfg);
    for (int j = 0; j < NB; j++) begin
      @(negedge clk);
      cfg_en = 1'b1;
      cfg_din = cfg[j];
      if (j > 0) begin
        check("R3 full hold", q_full, 2'b00);
        check("R3 fixed hold", q_fix, 2'b00);
      end
    end
    @(negedge clk);
    cfg_en = 1'b0;
    cfg_din = 1'b0;
  endtask

  task automatic apply(input logic [2:0] v);
    @(negedge clk);
    in_vec = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset full", q_full, 2'b00);
    check("R1 reset fixed", q_fix, 2'b00);
    rst = 1'b0;

    // R1: an empty chain gives 0 in full mode and 1 in fixed-OR mode.
    apply(3'd3);
    check("R1 empty cfg full", q_full, 2'b00);
    check("R1 empty cfg fixed", q_fix, 2'b11);

    in_vec = 3'd3;
    load(CFG_A);

    // R2 R4 R5 R7 R8: sweep every input combination.
    for (int n = 0; n < 8; n++) begin
      apply(VEC[n][6:4]);
      check("R2/R4/R5/R8 full sweep", q_full, VEC[n][3:2]);
      check("R7/R8 fixed sweep", q_fix, VEC[n][1:0]);
    end

    // R6: term a'c alone drives both full-mode outputs.
    apply(3'd4);
    check("R6 shared term", q_full, 2'b11);

    // R8: the output follows the new input one clock later.
    @(negedge clk);
    in_vec = 3'd3;
    check("R8 before edge", q_full, 2'b11);
    @(negedge clk);
    check("R8 after edge", q_full, 2'b01);

    // R9: toggle cfg_din while cfg_en is low, then sweep again.
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      cfg_din = j[0];
    end
    cfg_din = 1'b0;
    for (int n = 0; n < 8; n++) begin
      apply(VEC[n][6:4]);
      check("R9 full after idle din", q_full, VEC[n][3:2]);
      check("R9 fixed after idle din", q_fix, VEC[n][1:0]);
    end

    // R5 R7: with the OR plane cleared, full mode reads 0; fixed-OR mode is unchanged.
    load(CFG_B);
    for (int n = 0; n < 8; n++) begin
      apply(VEC[n][6:4]);
      check("R5 empty OR full", q_full, 2'b00);
      check("R7 OR bits ignored fixed", q_fix, VEC[n][1:0]);
    end

    // R1: a reset after loading clears the chain.
    load(CFG_A);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    apply(3'd3);
    check("R1 chain cleared full", q_full, 2'b00);
    check("R1 chain cleared fixed", q_fix, 2'b11);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule